// File: doc/BRIEF.md
# HDLC Frame Check Sequence Unit

This unit covers the frame-integrity work of a bit-serial HDLC controller. It sits between the flag and stuffing logic and the byte buffers. On receive, it is fed every line bit of a frame, with stuffing zeros marked. It keeps a 16-bit CRC over the data bits and counts octets. It watches the raw run of ones, and when the closing flag arrives it files the frame under one of five sticky status flags. It also packs the data into bytes. When automatic CRC handling is on, the two trailing check octets are held back from the byte output.

On transmit, it passes the frame's data bits through with one cycle of latency. At the end-of-frame strobe it shifts out the 16-bit frame check sequence, low-order bit first. A test control can corrupt that sequence on purpose. Each status flag has its own interrupt enable, and a single interrupt line is raised while any enabled flag is set.

Top module: `hdlc_fcs_unit`

## Requirements
- R1: With `cfg_auto_crc`=1, a frame that is aligned and not short sets the good flag (sts bit 0) if the CRC register holds 0xF0B8 at `rx_eof`. Otherwise it sets the CRC-error flag (sts bit 1). The CRC uses x^16+x^12+x^5+1, is preset to all ones, and takes data bits in arrival order.
- R2: Seven consecutive line ones inside a frame set the abort flag (sts bit 2) at once. The rest of that frame produces no bytes, and its `rx_eof` sets no flag.
- R3: At `rx_eof`, a data-bit count that is not a multiple of 8 sets the misalignment flag (sts bit 3). Good and CRC-error are then not set.
- R4: At `rx_eof`, a count of whole octets (check octets included) below `cfg_min_octets` sets the short flag (sts bit 4). Good and CRC-error are then not set. Misalignment may be set alongside it.
- R5: Received data is packed low-order bit first into `rx_byte`, with a one-cycle `rx_byte_vld` pulse per byte. With auto CRC on, the last two octets of a frame are never output. With it off, every octet is output, and an aligned, long-enough frame sets the good flag without any CRC test.
- R6: A bit marked by `rx_stuff` does not enter the data, the byte packing or the CRC, and it breaks the run of ones.
- R7: With `cfg_auto_crc`=1, after `tx_eof` the unit emits 16 more bits on `tx_out_bit`/`tx_out_vld`. They are the ones-complement of the CRC over the frame's data bits, sent low-order bit first, and `tx_busy` is high until the last is sent. Data bits appear one cycle after their input. With auto CRC off, no bits are appended.
- R8: With `cfg_force_err`=1 at `tx_eof`, the first appended bit (the CRC's least significant bit) is inverted. With auto CRC off, the control has no effect.
- R9: Each status flag stays set until its `sts_clr` bit is pulsed. A new event in the same cycle as a clear leaves the flag set.
- R10: `irq` is high exactly when some flag is set whose `irq_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_auto_crc | input | 1 | Automatic CRC generation and checking |
| cfg_force_err | input | 1 | Invert the first transmitted check bit |
| cfg_min_octets | input | MIN_W | Minimum received frame length in octets |
| rx_sof | input | 1 | Receive frame start strobe |
| rx_eof | input | 1 | Receive closing flag strobe |
| rx_bit_vld | input | 1 | Receive line bit strobe |
| rx_bit | input | 1 | Receive line bit value |
| rx_stuff | input | 1 | Current line bit is a stuffing zero |
| rx_byte | output | 8 | Received data byte |
| rx_byte_vld | output | 1 | Received byte strobe |
| tx_sof | input | 1 | Transmit frame start strobe |
| tx_eof | input | 1 | Transmit end of data strobe |
| tx_bit_vld | input | 1 | Transmit data bit strobe |
| tx_bit | input | 1 | Transmit data bit value |
| tx_out_bit | output | 1 | Outgoing bit |
| tx_out_vld | output | 1 | Outgoing bit strobe |
| tx_busy | output | 1 | Check sequence being shifted out |
| irq_en | input | 5 | Per-flag interrupt enables |
| sts_clr | input | 5 | Per-flag clear pulses |
| sts | output | 5 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
A CRC register out of step shows up at the first closing strobe. The frame lands on the wrong side of good and CRC-error one cycle after `rx_eof`, and on transmit the first appended bit already differs. A wrong ones-run or bit counter shows up as an abort, misalignment or short flag on a frame that should pass. It also shows up as a missing flag on a frame that should fail, one cycle after the faulty bit or strobe. Faults in the byte holding stage change the number or the values of `rx_byte` pulses within the same frame, so each frame is judged by its flags and its byte stream together.

// File: rtl/hdlc_fcs_pkg.sv
`timescale 1ns/1ps
package hdlc_fcs_pkg;
   localparam int NFLAG    = 5;
   localparam int F_GOOD   = 0;
   localparam int F_CRCERR = 1;
   localparam int F_ABORT  = 2;
   localparam int F_MISAL  = 3;
   localparam int F_SHORT  = 4;
   localparam int ABORT_RUN = 7;
endpackage

// File: rtl/hdlc_crc_reg.sv
`timescale 1ns/1ps
module hdlc_crc_reg #(
   parameter int          CRC_W  = 16,
   parameter logic [15:0] POLY   = 16'h8408,
   parameter logic [15:0] PRESET = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             en,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   logic [CRC_W-1:0] nxt;
   logic             fb;

   // bit-serial reflected update: shift toward bit 0, fold in the polynomial
   always_comb begin
      fb  = crc[0] ^ din;
      nxt = crc >> 1;
      if (fb) nxt = nxt ^ POLY[CRC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= PRESET[CRC_W-1:0];
      else if (init) crc <= PRESET[CRC_W-1:0];
      else if (en)   crc <= nxt;
   end
endmodule

// File: rtl/hdlc_rx_check.sv
`timescale 1ns/1ps
module hdlc_rx_check
   import hdlc_fcs_pkg::*;
#(
   parameter int          CNT_W   = 16,
   parameter int          MIN_W   = 8,
   parameter int          CRC_W   = 16,
   parameter logic [15:0] POLY    = 16'h8408,
   parameter logic [15:0] RESIDUE = 16'hF0B8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_crc,
   input  logic [MIN_W-1:0] min_octets,
   input  logic             sof,
   input  logic             eof,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             stuff,
   output logic [7:0]       byte_out,
   output logic             byte_vld,
   output logic [NFLAG-1:0] ev
);
   localparam int OCT_W = CNT_W - 3;

   logic [CRC_W-1:0] crc;
   logic [CNT_W-1:0] bitcnt;
   logic [2:0]       ones;
   logic             active;
   logic [7:0]       shreg;
   logic [7:0]       hold_old, hold_new;
   logic [1:0]       held;
   logic             data_bit, abort_now, byte_done, closing;
   logic             aligned, too_short, len_ok, crc_ok;
   logic [7:0]       new_byte;

   always_comb begin
      abort_now = active && bit_vld && bit_in && !stuff && (ones == 3'(ABORT_RUN - 1));
      data_bit  = active && bit_vld && !stuff && !abort_now;
      byte_done = data_bit && (bitcnt[2:0] == 3'd7);
      new_byte  = {bit_in, shreg[7:1]};
      closing   = eof && active;
      aligned   = (bitcnt[2:0] == 3'd0);
      too_short = bitcnt[CNT_W-1:3] < OCT_W'(min_octets);
      len_ok    = aligned && !too_short;
      crc_ok    = (crc == RESIDUE[CRC_W-1:0]);
      ev           = '0;
      ev[F_ABORT]  = abort_now;
      ev[F_MISAL]  = closing && !aligned;
      ev[F_SHORT]  = closing && too_short;
      ev[F_GOOD]   = closing && len_ok && (!auto_crc || crc_ok);
      ev[F_CRCERR] = closing && len_ok && auto_crc && !crc_ok;
   end

   hdlc_crc_reg #(.CRC_W(CRC_W), .POLY(POLY), .PRESET(16'hFFFF)) i_crc (
      .clk(clk), .rst_n(rst_n), .init(sof), .en(data_bit), .din(bit_in), .crc(crc)
   );

   // line state: run of ones, frame activity, data bit count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones   <= '0;
         active <= 1'b0;
         bitcnt <= '0;
         shreg  <= '0;
      end else if (sof) begin
         ones   <= '0;
         active <= 1'b1;
         bitcnt <= '0;
      end else begin
         if (bit_vld) ones <= (bit_in && !stuff) ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
         if (abort_now || eof) active <= 1'b0;
         if (data_bit) begin
            shreg <= new_byte;
            if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
         end
      end
   end

   // byte output; with auto CRC the two newest octets wait in a holding pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_out <= '0;
         byte_vld <= 1'b0;
         hold_old <= '0;
         hold_new <= '0;
         held     <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (sof) held <= '0;
         else if (byte_done) begin
            if (!auto_crc) begin
               byte_out <= new_byte;
               byte_vld <= 1'b1;
            end else if (held == 2'd2) begin
               byte_out <= hold_old;
               byte_vld <= 1'b1;
               hold_old <= hold_new;
               hold_new <= new_byte;
            end else if (held == 2'd1) begin
               hold_new <= new_byte;
               held     <= 2'd2;
            end else begin
               hold_old <= new_byte;
               held     <= 2'd1;
            end
         end
      end
   end

   p_byte_from_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(bit_vld && !stuff));
   p_abort_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev[F_ABORT] |=> !byte_vld);
   p_misal_no_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev[F_MISAL] |-> !ev[F_GOOD] && !ev[F_CRCERR]);
   p_short_no_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev[F_SHORT] |-> !ev[F_GOOD] && !ev[F_CRCERR]);
endmodule

// File: rtl/hdlc_tx_fcs.sv
`timescale 1ns/1ps
module hdlc_tx_fcs #(
   parameter int          CRC_W = 16,
   parameter logic [15:0] POLY  = 16'h8408
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_crc,
   input  logic force_err,
   input  logic sof,
   input  logic eof,
   input  logic bit_vld,
   input  logic bit_in,
   output logic out_bit,
   output logic out_vld,
   output logic busy
);
   localparam int LEFT_W = $clog2(CRC_W + 1);

   logic [CRC_W-1:0]  crc;
   logic [CRC_W-1:0]  sh;
   logic [LEFT_W-1:0] left;

   hdlc_crc_reg #(.CRC_W(CRC_W), .POLY(POLY), .PRESET(16'hFFFF)) i_crc (
      .clk(clk), .rst_n(rst_n), .init(sof), .en(bit_vld), .din(bit_in), .crc(crc)
   );

   assign busy = (left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_bit <= 1'b0;
         out_vld <= 1'b0;
         sh      <= '0;
         left    <= '0;
      end else begin
         out_vld <= 1'b0;
         if (bit_vld) begin
            out_bit <= bit_in;
            out_vld <= 1'b1;
         end else if (busy) begin
            out_bit <= sh[0];
            out_vld <= 1'b1;
            sh      <= sh >> 1;
            left    <= left - 1'b1;
         end
         if (eof && auto_crc) begin
            sh   <= ~crc ^ CRC_W'(force_err);
            left <= LEFT_W'(CRC_W);
         end
      end
   end

   p_fcs_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> out_vld);
   p_no_data_in_fcs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !bit_vld);
   p_manual_no_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eof && !auto_crc && !busy) |=> !busy);
endmodule

// File: rtl/hdlc_fcs_unit.sv
`timescale 1ns/1ps
module hdlc_fcs_unit
   import hdlc_fcs_pkg::*;
#(
   parameter int          CNT_W   = 16,
   parameter int          MIN_W   = 8,
   parameter int          CRC_W   = 16,
   parameter logic [15:0] POLY    = 16'h8408,
   parameter logic [15:0] RESIDUE = 16'hF0B8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_auto_crc,
   input  logic             cfg_force_err,
   input  logic [MIN_W-1:0] cfg_min_octets,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic             rx_bit_vld,
   input  logic             rx_bit,
   input  logic             rx_stuff,
   output logic [7:0]       rx_byte,
   output logic             rx_byte_vld,
   input  logic             tx_sof,
   input  logic             tx_eof,
   input  logic             tx_bit_vld,
   input  logic             tx_bit,
   output logic             tx_out_bit,
   output logic             tx_out_vld,
   output logic             tx_busy,
   input  logic [4:0]       irq_en,
   input  logic [4:0]       sts_clr,
   output logic [4:0]       sts,
   output logic             irq
);
   logic [NFLAG-1:0] ev;

   if (CNT_W < MIN_W + 3) begin : g_bad_cnt
      $error("CNT_W must cover MIN_W octets plus three bit positions");
   end
   if (CRC_W < 8 || CRC_W > 16) begin : g_bad_crc
      $error("CRC_W must lie between 8 and 16");
   end
   if (NFLAG != 5) begin : g_bad_flags
      $error("status port width expects five flags");
   end

   hdlc_rx_check #(
      .CNT_W(CNT_W), .MIN_W(MIN_W), .CRC_W(CRC_W), .POLY(POLY), .RESIDUE(RESIDUE)
   ) i_rx (
      .clk(clk), .rst_n(rst_n), .auto_crc(cfg_auto_crc), .min_octets(cfg_min_octets),
      .sof(rx_sof), .eof(rx_eof), .bit_vld(rx_bit_vld), .bit_in(rx_bit),
      .stuff(rx_stuff), .byte_out(rx_byte), .byte_vld(rx_byte_vld), .ev(ev)
   );

   hdlc_tx_fcs #(.CRC_W(CRC_W), .POLY(POLY)) i_tx (
      .clk(clk), .rst_n(rst_n), .auto_crc(cfg_auto_crc), .force_err(cfg_force_err),
      .sof(tx_sof), .eof(tx_eof), .bit_vld(tx_bit_vld), .bit_in(tx_bit),
      .out_bit(tx_out_bit), .out_vld(tx_out_vld), .busy(tx_busy)
   );

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= ev[i] | (q & ~sts_clr[i]);
      end
      assign sts[i] = q;

      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (q && !sts_clr[i]) |=> q);
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> q);
   end

   assign irq = |(sts & irq_en);

   p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (sts != '0));
endmodule

// File: tb/test_hdlc_fcs_unit.sv
`timescale 1ns/1ps
module test_hdlc_fcs_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_auto_crc = 1'b1, cfg_force_err = 1'b0;
   logic [7:0] cfg_min_octets = 8'd3;
   logic rx_sof = 0, rx_eof = 0, rx_bit_vld = 0, rx_bit = 0, rx_stuff = 0;
   logic [7:0] rx_byte;
   logic rx_byte_vld;
   logic tx_sof = 0, tx_eof = 0, tx_bit_vld = 0, tx_bit = 0;
   logic tx_out_bit, tx_out_vld, tx_busy;
   logic [4:0] irq_en = '0, sts_clr = '0;
   logic [4:0] sts;
   logic irq;

   int checks = 0, failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   hdlc_fcs_unit i_hdlc_fcs_unit (
      .clk(clk), .rst_n(rst_n), .cfg_auto_crc(cfg_auto_crc), .cfg_force_err(cfg_force_err),
      .cfg_min_octets(cfg_min_octets), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .rx_stuff(rx_stuff), .rx_byte(rx_byte),
      .rx_byte_vld(rx_byte_vld), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_bit_vld(tx_bit_vld),
      .tx_bit(tx_bit), .tx_out_bit(tx_out_bit), .tx_out_vld(tx_out_vld), .tx_busy(tx_busy),
      .irq_en(irq_en), .sts_clr(sts_clr), .sts(sts), .irq(irq)
   );

   // capture of outputs away from the active edge
   logic [7:0] rx_got [8];
   int rx_cnt = 0;
   logic [63:0] tx_got = '0;
   int tx_cnt = 0;
   bit busy_seen = 0;
   always @(negedge clk) begin
      if (rx_byte_vld) begin
         if (rx_cnt < 8) rx_got[rx_cnt] = rx_byte;
         rx_cnt++;
      end
      if (tx_out_vld) begin
         if (tx_cnt < 64) tx_got[tx_cnt] = tx_out_bit;
         tx_cnt++;
      end
      if (tx_busy) busy_seen = 1;
   end

   task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // ones-complement of the reflected CCITT CRC over n bytes, low bit first
   function automatic logic [15:0] fcs_of(input int n, input logic [31:0] d);
      logic [15:0] r = 16'hFFFF;
      for (int k = 0; k < 8 * n; k++) begin
         if (r[0] != d[k]) r = (r >> 1) ^ 16'h8408;
         else              r = r >> 1;
      end
      return ~r;
   endfunction

   int run1 = 0;
   task automatic step();
      @(posedge clk); #2;
      rx_sof = 0; rx_eof = 0; rx_bit_vld = 0; rx_bit = 0; rx_stuff = 0; sts_clr = '0;
      tx_sof = 0; tx_eof = 0; tx_bit_vld = 0; tx_bit = 0;
   endtask

   task automatic send_data_bit(input logic b);
      step(); rx_bit_vld = 1; rx_bit = b;
      run1 = b ? run1 + 1 : 0;
      if (run1 == 5) begin
         step(); rx_bit_vld = 1; rx_bit = 0; rx_stuff = 1;
         run1 = 0;
      end
   endtask

   task automatic rx_frame(input int n, input logic [31:0] d, input bit bad, input int extra, input bit clr0_at_eof);
      logic [15:0] f;
      rx_cnt = 0;
      step(); rx_sof = 1; run1 = 0;
      for (int k = 0; k < 8 * n; k++) send_data_bit(d[k]);
      f = fcs_of(n, d) ^ {15'd0, bad};
      for (int k = 0; k < 16; k++) send_data_bit(f[k]);
      for (int k = 0; k < extra; k++) send_data_bit(1'b0);
      step(); rx_eof = 1; if (clr0_at_eof) sts_clr = 5'b00001;
      step(); step(); step();
   endtask

   task automatic clear_all();
      step(); sts_clr = 5'h1F;
      step(); step();
   endtask

   task automatic tx_frame(input int n, input logic [31:0] d);
      tx_cnt = 0; tx_got = '0; busy_seen = 0;
      step(); tx_sof = 1;
      for (int k = 0; k < 8 * n; k++) begin step(); tx_bit_vld = 1; tx_bit = d[k]; end
      step(); tx_eof = 1;
      repeat (24) step();
   endtask

   // {n_oct[2:0], data[31:0], bad_fcs, extra[2:0], exp_sts[4:0], exp_bytes[2:0]}
   localparam logic [46:0] VEC [8] = '{
      {3'd2, 32'h0000_3412, 1'b0, 3'd0, 5'b00001, 3'd2},
      {3'd3, 32'h00A5_C381, 1'b0, 3'd0, 5'b00001, 3'd3},
      {3'd2, 32'h0000_7E7E, 1'b1, 3'd0, 5'b00010, 3'd2},
      {3'd1, 32'h0000_00FF, 1'b0, 3'd0, 5'b00001, 3'd1},
      {3'd0, 32'h0000_0000, 1'b0, 3'd0, 5'b10000, 3'd0},
      {3'd2, 32'h0000_F00F, 1'b0, 3'd3, 5'b01000, 3'd2},
      {3'd0, 32'h0000_0000, 1'b0, 3'd1, 5'b11000, 3'd0},
      {3'd4, 32'hDEAD_BEEF, 1'b0, 3'd0, 5'b00001, 3'd4}
   };

   initial begin
      #(20 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] exp_tx;
      logic [15:0] f;
      repeat (4) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      check("R9", "reset status", sts, 0);
      check("R10", "reset irq", irq, 0);
      check("R7", "reset busy", tx_busy, 0);

      // table: R1 R3 R4 R5 R6 (entry 3 carries stuffing of 0xFF, R6)
      for (int i = 0; i < 8; i++) begin
         logic [31:0] got32;
         string tag;
         clear_all();
         rx_frame(VEC[i][46:44], VEC[i][43:12], VEC[i][11], VEC[i][10:8], 0);
         tag = VEC[i][7] ? "R4" : VEC[i][6] ? "R3" : (i == 3) ? "R6" : "R1";
         check(tag, $sformatf("vector %0d status", i), sts, VEC[i][7:3]);
         check("R5", $sformatf("vector %0d byte count", i), rx_cnt, VEC[i][2:0]);
         got32 = '0;
         for (int b = 0; b < 4; b++) if (b < rx_cnt) got32[8*b +: 8] = rx_got[b];
         check("R5", $sformatf("vector %0d bytes", i), got32,
               VEC[i][43:12] & ((32'h1 << (8 * VEC[i][2:0])) - 1) | ((VEC[i][2:0] == 4) ? VEC[i][43:12] : 32'h0));
      end

      // R5: auto CRC off passes all octets and skips the CRC test
      clear_all();
      cfg_auto_crc = 0;
      rx_frame(2, 32'h0000_5AC3, 1, 0, 0);
      check("R5", "manual mode status", sts, 5'b00001);
      check("R5", "manual mode byte count", rx_cnt, 4);
      f = fcs_of(2, 32'h5AC3) ^ 16'h1;
      check("R5", "manual mode bytes", {rx_got[3], rx_got[2], rx_got[1], rx_got[0]}, {f, 16'h5AC3});

      // R2: abort by seven raw ones after one byte, manual mode
      clear_all();
      rx_cnt = 0;
      step(); rx_sof = 1; run1 = 0;
      for (int k = 0; k < 8; k++) send_data_bit(k == 0 || k == 4);
      for (int k = 0; k < 7; k++) begin step(); rx_bit_vld = 1; rx_bit = 1; end
      step(); step();
      check("R2", "abort flag", sts, 5'b00100);
      step(); rx_eof = 1;
      step(); step();
      check("R2", "no status at eof after abort", sts, 5'b00100);
      check("R2", "bytes before abort only", rx_cnt, 1);
      cfg_auto_crc = 1;

      // R9: sticky, selective clear, set wins over clear
      clear_all();
      rx_frame(2, 32'h0000_3412, 0, 0, 0);
      repeat (5) step();
      check("R9", "good flag holds", sts, 5'b00001);
      rx_frame(2, 32'h0000_7E7E, 1, 0, 0);
      step(); sts_clr = 5'b00001;
      step(); step();
      check("R9", "clear only bit 0", sts, 5'b00010);
      clear_all();
      rx_frame(2, 32'h0000_3412, 0, 0, 1);
      check("R9", "set wins over clear", sts, 5'b00001);

      // R10: interrupt follows enabled flags
      clear_all();
      irq_en = 5'b00010;
      rx_frame(2, 32'h0000_3412, 0, 0, 0);
      check("R10", "good flag not enabled", irq, 0);
      rx_frame(2, 32'h0000_3412, 1, 0, 0);
      check("R10", "crc flag enabled", irq, 1);
      step(); sts_clr = 5'b00010;
      step(); step();
      check("R10", "irq drops on clear", irq, 0);
      irq_en = 5'b00001;
      step(); step();
      check("R10", "enable existing flag", irq, 1);
      irq_en = '0;

      // R7: transmit with appended check sequence
      cfg_auto_crc = 1; cfg_force_err = 0;
      tx_frame(2, 32'h0000_3412);
      f = fcs_of(2, 32'h3412);
      exp_tx = {32'h0, f, 16'h3412};
      check("R7", "tx bit count", tx_cnt, 32);
      check("R7", "tx bits", tx_got, exp_tx);
      check("R7", "busy seen", busy_seen, 1);
      tx_frame(3, 32'h00A5_C381);
      f = fcs_of(3, 32'hA5C381);
      check("R7", "tx bits 3 octets", tx_got, {24'h0, f, 24'hA5C381});

      // R8: forced error inverts first check bit; no effect in manual mode
      cfg_force_err = 1;
      tx_frame(2, 32'h0000_3412);
      f = fcs_of(2, 32'h3412) ^ 16'h1;
      check("R8", "forced error bits", tx_got, {32'h0, f, 16'h3412});
      cfg_auto_crc = 0;
      tx_frame(2, 32'h0000_3412);
      check("R8", "manual tx bit count", tx_cnt, 16);
      check("R8", "manual tx bits", tx_got, {48'h0, 16'h3412});
      check("R7", "manual tx never busy", busy_seen, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule